// File: doc/BRIEF.md
# Multi-Function Integer ALU with Flags

A purely combinational 32-bit arithmetic-logic unit. Two operands, `opnd_x` and `opnd_y`, and a 4-bit operation code produce one result word. The unit supports shifts, bitwise logic, a half-word merge, signed multiply, signed divide, a reversed subtract (y minus x) and add. There is no clock and no stored state, so the outputs follow the inputs within the same cycle.

Three signed comparison flags are driven on every operation, whatever the code. Three exception flags report add overflow, subtract overflow and a zero divisor. Each exception flag can only be raised while its own operation is selected. The datapath is meant to sit in the execute stage of a simple pipelined core.

Top module: `int_alu`

## Requirements
- R1: With `op_sel` = 0 the result is `opnd_x` shifted left by `opnd_y[4:0]`, with zeros filling from the right.
- R2: With `op_sel` = 1 the result is `opnd_x` shifted right logically by `opnd_y[4:0]`, with zeros filling from the left.
- R3: Bits 31..5 of `opnd_y` have no effect on either shift result.
- R4: The result is x AND y for code 2, x OR y for code 3 and x XOR y for code 4.
- R5: With code 5 the result has `opnd_y[15:0]` in bits 31..16 and `opnd_x[15:0]` in bits 15..0.
- R6: With code 6 the result is the low 32 bits of the signed 64-bit product x*y.
- R7: With code 7 the result is the signed quotient x/y, truncated toward zero. A zero divisor gives 0. 0x80000000 divided by -1 gives 0x80000000.
- R8: With code 8 the result is y - x, modulo 2^32.
- R9: Every code from 9 to 15 gives x + y, modulo 2^32.
- R10: `flag_lt`, `flag_eq` and `flag_gt` give the signed comparison of x against y for every code. Exactly one of them is 1.
- R11: `ovf_add` is 1 exactly when the code is in 9..15 and the signed sum x + y falls outside the 32-bit signed range.
- R12: `ovf_sub` is 1 exactly when the code is 8 and the signed difference y - x falls outside the 32-bit signed range.
- R13: `div_zero` is 1 exactly when the code is 7 and `opnd_y` is 0.
- R14: No output is unknown while all inputs are known, including for a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | 32 | First operand |
| opnd_y | input | 32 | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Selected result |
| flag_lt | output | 1 | x less than y, signed |
| flag_eq | output | 1 | x equal to y |
| flag_gt | output | 1 | x greater than y, signed |
| ovf_add | output | 1 | Signed overflow of an add |
| ovf_sub | output | 1 | Signed overflow of the reversed subtract |
| div_zero | output | 1 | Divide with a zero divisor |

## Verification
The bench goes after these corner cases:
- **Shift counts.** It uses `opnd_y` with large upper bits. A shifter that reads the whole of y would return zero for these values.
- **Division edges.** It divides the most negative value by -1, uses zero divisors and uses mixed-sign operands. A native signed divide would produce unknowns or trap on the first two. Rounding toward minus infinity would be off by one on the mixed-sign cases.
- **Subtract operand order.** It takes differences across the sign boundary. An x - y datapath would get the sign of the result wrong and raise its overflow flag on the wrong operands.
- **Flag gating.** It drives overflowing operands with non-arithmetic codes. An ungated flag would be raised on those codes.
- **Comparison sign.** It compares negative values with positive ones. An unsigned comparator would report greater-than where less-than is correct.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SHL   = 4'd0,
    OP_SHR   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_MERGE = 4'd5,
    OP_MUL   = 4'd6,
    OP_DIV   = 4'd7,
    OP_RSUB  = 4'd8,
    OP_ADD   = 4'd9
  } alu_op_e;

  // Codes from OP_ADD upward all select addition.
  function automatic logic is_add_code(input logic [OP_W-1:0] code);
    return code >= OP_ADD;
  endfunction
endpackage

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] bit_res
);
  localparam int SH_W = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;

  logic [SH_W-1:0]  shamt;
  logic [WIDTH-1:0] merged;

  assign shamt = opnd_y[SH_W-1:0];

  generate
    if (HALF > 0) begin : g_merge
      assign merged = {opnd_y[HALF-1:0], opnd_x[HALF-1:0]};
    end
  endgenerate

  always_comb begin
    unique case (op_sel)
      OP_SHL:   bit_res = opnd_x << shamt;
      OP_SHR:   bit_res = opnd_x >> shamt;
      OP_AND:   bit_res = opnd_x & opnd_y;
      OP_OR:    bit_res = opnd_x | opnd_y;
      OP_XOR:   bit_res = opnd_x ^ opnd_y;
      OP_MERGE: bit_res = merged;
      default:  bit_res = '0;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] rdiff,
  output logic             sum_ovf,
  output logic             rdiff_ovf
);
  localparam int MSB = WIDTH - 1;

  assign sum   = opnd_x + opnd_y;
  assign rdiff = opnd_y - opnd_x;

  // Same-sign addends whose sum changes sign.
  assign sum_ovf   = (opnd_x[MSB] == opnd_y[MSB]) && (sum[MSB] != opnd_x[MSB]);
  // Opposite-sign operands whose difference takes the sign of x.
  assign rdiff_ovf = (opnd_x[MSB] != opnd_y[MSB]) && (rdiff[MSB] != opnd_y[MSB]);
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic [WIDTH-1:0] prod,
  output logic [WIDTH-1:0] quot,
  output logic             y_zero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] mag_x, mag_y, mag_q;
  logic             neg_q;

  // The low half of the product is the same for signed and unsigned operands.
  assign prod = opnd_x * opnd_y;

  assign y_zero = (opnd_y == '0);
  assign mag_x  = opnd_x[MSB] ? (~opnd_x + 1'b1) : opnd_x;
  assign mag_y  = opnd_y[MSB] ? (~opnd_y + 1'b1) : opnd_y;
  assign neg_q  = opnd_x[MSB] ^ opnd_y[MSB];

  always_comb begin
    if (y_zero) begin
      mag_q = '0;
    end else begin
      mag_q = mag_x / mag_y;
    end
  end

  assign quot = neg_q ? (~mag_q + 1'b1) : mag_q;
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic             is_lt,
  output logic             is_eq,
  output logic             is_gt
);
  assign is_lt = $signed(opnd_x) < $signed(opnd_y);
  assign is_eq = (opnd_x == opnd_y);
  assign is_gt = !is_lt && !is_eq;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_lt,
  output logic             flag_eq,
  output logic             flag_gt,
  output logic             ovf_add,
  output logic             ovf_sub,
  output logic             div_zero
);
  logic [WIDTH-1:0] bit_res, sum, rdiff, prod, quot;
  logic             sum_ovf, rdiff_ovf, y_zero;

  alu_bitops #(.WIDTH(WIDTH)) u_bitops (
    .opnd_x (opnd_x),
    .opnd_y (opnd_y),
    .op_sel (op_sel),
    .bit_res(bit_res)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opnd_x   (opnd_x),
    .opnd_y   (opnd_y),
    .sum      (sum),
    .rdiff    (rdiff),
    .sum_ovf  (sum_ovf),
    .rdiff_ovf(rdiff_ovf)
  );

  alu_muldiv #(.WIDTH(WIDTH)) u_muldiv (
    .opnd_x(opnd_x),
    .opnd_y(opnd_y),
    .prod  (prod),
    .quot  (quot),
    .y_zero(y_zero)
  );

  alu_cmp #(.WIDTH(WIDTH)) u_cmp (
    .opnd_x(opnd_x),
    .opnd_y(opnd_y),
    .is_lt (flag_lt),
    .is_eq (flag_eq),
    .is_gt (flag_gt)
  );

  always_comb begin
    if (is_add_code(op_sel)) begin
      result = sum;
    end else begin
      unique case (op_sel)
        OP_MUL:  result = prod;
        OP_DIV:  result = quot;
        OP_RSUB: result = rdiff;
        default: result = bit_res;
      endcase
    end
  end

  assign ovf_add  = is_add_code(op_sel) && sum_ovf;
  assign ovf_sub  = (op_sel == OP_RSUB) && rdiff_ovf;
  assign div_zero = (op_sel == OP_DIV) && y_zero;
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_x,
  input logic [WIDTH-1:0] opnd_y,
  input logic [OP_W-1:0]  op_sel,
  input logic [WIDTH-1:0] result,
  input logic             flag_lt,
  input logic             flag_eq,
  input logic             flag_gt,
  input logic             ovf_add,
  input logic             ovf_sub,
  input logic             div_zero
);
  localparam int HALF = WIDTH / 2;

  logic inputs_known;
  assign inputs_known = !$isunknown({opnd_x, opnd_y, op_sel});

  always_comb begin
    if (inputs_known) begin
      assert_cmp_onehot_R10: assert ($countones({flag_lt, flag_eq, flag_gt}) == 1);
      assert_add_ovf_gated_R11: assert (!ovf_add || is_add_code(op_sel));
      assert_sub_ovf_gated_R12: assert (!ovf_sub || op_sel == OP_RSUB);
      assert_div_zero_flag_R13: assert (div_zero == (op_sel == OP_DIV && opnd_y == '0));
      assert_merge_halves_R5: assert (op_sel != OP_MERGE ||
                                       result == {opnd_y[HALF-1:0], opnd_x[HALF-1:0]});
      assert_div_zero_result_R7: assert (!div_zero || result == '0);
      assert_outputs_known_R14: assert (!$isunknown({result, flag_lt, flag_eq, flag_gt,
                                                     ovf_add, ovf_sub, div_zero}));
    end
  end
endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH)) u_int_alu_checker (
  .opnd_x  (opnd_x),
  .opnd_y  (opnd_y),
  .op_sel  (op_sel),
  .result  (result),
  .flag_lt (flag_lt),
  .flag_eq (flag_eq),
  .flag_gt (flag_gt),
  .ovf_add (ovf_add),
  .ovf_sub (ovf_sub),
  .div_zero(div_zero)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
  logic        clk;
  logic [31:0] opnd_x, opnd_y;
  logic [3:0]  op_sel;
  logic [31:0] result;
  logic        flag_lt, flag_eq, flag_gt, ovf_add, ovf_sub, div_zero;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int_alu dut (
    .opnd_x(opnd_x), .opnd_y(opnd_y), .op_sel(op_sel), .result(result),
    .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_gt(flag_gt),
    .ovf_add(ovf_add), .ovf_sub(ovf_sub), .div_zero(div_zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op %0d x %h y %h)",
               tag, act, exp, op_sel, opnd_x, opnd_y);
    end
  endtask

  function automatic logic [31:0] model_res(input logic [3:0] op, input logic [31:0] x,
                                            input logic [31:0] y);
    longint px, py;
    px = longint'($signed(x));
    py = longint'($signed(y));
    case (op)
      4'd0: return x << y[4:0];
      4'd1: return x >> y[4:0];
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return x ^ y;
      4'd5: return {y[15:0], x[15:0]};
      4'd6: return 32'(px * py);
      4'd7: begin
        if (y == 32'd0) return 32'd0;
        return 32'(px / py);  // 64-bit signed divide truncates toward zero, no overflow
      end
      4'd8: return 32'(py - px);
      default: return 32'(px + py);
    endcase
  endfunction

  function automatic logic out_of_range(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y,
                       input string extra);
    longint px, py;
    @(negedge clk);
    op_sel = op; opnd_x = x; opnd_y = y;
    #2;
    px = longint'($signed(x));
    py = longint'($signed(y));
    chk({res_tag(op), extra}, result, model_res(op, x, y));
    chk("R10 lt", {31'd0, flag_lt}, {31'd0, px < py});
    chk("R10 eq", {31'd0, flag_eq}, {31'd0, px == py});
    chk("R10 gt", {31'd0, flag_gt}, {31'd0, px > py});
    chk("R11", {31'd0, ovf_add}, {31'd0, (op >= 4'd9) && out_of_range(px + py)});
    chk("R12", {31'd0, ovf_sub}, {31'd0, (op == 4'd8) && out_of_range(py - px)});
    chk("R13", {31'd0, div_zero}, {31'd0, (op == 4'd7) && (y == 32'd0)});
    chk("R14", {31'd0, $isunknown({result, flag_lt, flag_eq, flag_gt,
                                   ovf_add, ovf_sub, div_zero})}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd20240611));
    // Initial idle pattern.
    apply(4'd0, 32'd0, 32'd0, " idle");
    // R1 R2 R3: shifts with junk in the upper bits of y.
    apply(4'd0, 32'h0000_00F1, 32'hFFFF_FFE4, " R3 shl");
    apply(4'd1, 32'h8000_0001, 32'h1234_567F, " R3 shr");
    apply(4'd1, 32'hF000_0000, 32'd4, " logical");
    apply(4'd0, 32'h1, 32'h20, " R3 count0");
    // R4 R5.
    apply(4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, "");
    apply(4'd3, 32'hF0F0_0000, 32'h0000_00FF, "");
    apply(4'd4, 32'hAAAA_5555, 32'hFFFF_0000, "");
    apply(4'd5, 32'hDEAD_BEEF, 32'hCAFE_F00D, "");
    // R6.
    apply(4'd6, 32'hFFFF_FFFD, 32'd7, " neg");
    apply(4'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF, " wide");
    // R7 divide corner cases.
    apply(4'd7, 32'h8000_0000, 32'hFFFF_FFFF, " min/-1");
    apply(4'd7, 32'd12345, 32'd0, " zero");
    apply(4'd7, 32'hFFFF_FFF9, 32'd2, " -7/2");
    apply(4'd7, 32'd7, 32'hFFFF_FFFE, " 7/-2");
    // R8 R12.
    apply(4'd8, 32'd1, 32'h8000_0000, " ovf");
    apply(4'd8, 32'h8000_0000, 32'd0, " ovf2");
    apply(4'd8, 32'd5, 32'd3, "");
    // R9 R11 on every add alias.
    for (int c = 9; c < 16; c++) apply(4'(c), 32'h7FFF_FFFF, 32'd1, " alias");
    apply(4'd15, 32'h8000_0000, 32'h8000_0000, " negovf");
    // R11 R12 gating: overflowing operands on other codes.
    for (int c = 0; c < 9; c++) apply(4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF, " gate");
    // R10: sign-sensitive comparison.
    apply(4'd2, 32'hFFFF_FFFF, 32'd1, " cmp");
    apply(4'd9, 32'd1, 32'hFFFF_FFFF, " cmp");
    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) b = b & 32'hF;
      if (i % 11 == 0) a = b;
      apply(4'($urandom_range(0, 15)), a, b, " rand");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule